// File: doc/BRIEF.md
# Paged SPI Register Slave

This block is a mode-0 SPI slave that gives an external host burst access to a space of 16-bit registers. Each frame, framed by chip select, begins with a short header. The header names a page, a starting word offset, a direction and a word count. The data words then follow. The block decodes the header and counts the words. For every word it raises a one-cycle strobe on a simple internal register port, with the address incremented word by word.

Page 0 is reached with a two-byte header. Every other page is reached through an escape byte followed by a page byte, an offset byte and the length byte. One page is a firmware window. Its addresses are built from a 32-bit base that the host writes into two page-0 words. The SPI pins are oversampled in the system clock domain. The register contents are held outside the block: writes leave on the port, and read data is taken from the port in the strobe cycle.

Top module: `paged_spi_regs`

## Requirements
- R1: A first byte with bit 7 set, other than 0xFE, selects page 0 with word offset = bits [6:0]. Each strobe then carries reg_addr = {16'h0000, 8'h00, word, 1'b0} with reg_fw low.
- R2: A first byte of 0xFE starts a paged header of four bytes: escape, page byte p, offset byte (bits [6:0]), length byte. A page byte p in 0x00..0xFD selects page p+1, and reg_addr = {16'h0000, p+1, word, 1'b0} with reg_fw low.
- R3: A page byte of 0xFF selects the firmware window. reg_fw is high and reg_addr = {base[31:8], word, 1'b0}.
- R4: A write to page 0 word 6 loads base[31:16]. A write to page 0 word 7 loads base[15:8], and bits [7:0] of that word's data are not used. Both writes still appear on the register port.
- R5: In the length byte, bits [6:0] hold the word count minus one (1 to 128 words), and bit 7 is 1 for a write and 0 for a read. Words clocked after the count is used up produce no strobe.
- R6: Write words arrive MSB first, high byte before low byte. After the 16th bit of each word, reg_wr_en pulses for exactly one cycle with that word on reg_wdata.
- R7: A read raises a one-cycle reg_rd_en per word. The first pulse comes when the length byte completes. reg_rdata is taken in the strobe cycle and shifted out on spi_miso MSB first, with each bit changing after a falling SCLK edge.
- R8: The word offset advances by one after every transferred word and wraps within 7 bits.
- R9: Raising chip select ends any burst. A partial word gives no strobe, and the next frame is decoded from a fresh header.
- R10: A frame whose first byte has bit 7 clear, or whose page byte is 0xFE, is ignored to its end: no strobes, and spi_miso stays low.
- R11: During and right after reset, reg_wr_en, reg_rd_en and spi_miso are low.
- R12: spi_miso is low while no read data is being shifted, including after a read's word count is used up and while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_fw | output | 1 | Strobe targets the firmware window |
| reg_addr | output | 2*DATA_W | Byte address of the word being accessed |
| reg_wdata | output | DATA_W | Write data, valid with reg_wr_en |
| reg_rdata | input | DATA_W | Read data, sampled while reg_rd_en is high |

## Verification
The hardest case to reach from the pins is a chip select that rises in the middle of a data word. That word must give no strobe, and the header decoder must start clean on the next frame. The stimulus starts a two-word write, sends one whole word and half of the next, and releases chip select. It then runs a read frame and checks its header and data. A second hard case is the read hand-off, where the next word has to be loaded after the 16th rising edge but before the falling edge that presents its MSB. Multi-word reads, and a read clocked past its count, exercise that hand-off. A 128-word write exercises the end of the counter and the offset wrap.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [2:0] {
    ST_CMD,
    ST_PAGE,
    ST_OFFS,
    ST_LEN,
    ST_WDATA,
    ST_RDATA,
    ST_DROP
  } psr_state_e;

  localparam int          PTR_W        = 7;
  localparam logic [7:0]  PAGED_ESCAPE = 8'hFE;
  localparam logic [7:0]  FW_PAGE_CODE = 8'hFF;
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] r;
    logic [WIDTH-1:0] r_in;
    if (s == 0) begin : g_first
      assign r_in = d;
    end else begin : g_next
      assign r_in = g_stage[s-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_VAL;
      else        r <= r_in;
    end
  end

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/psr_addr.sv
module psr_addr
  import psr_pkg::*;
#(
  parameter int               DATA_W    = 16,
  parameter logic [PTR_W-1:0] BASE_WORD = 7'd6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_direct,
  input  logic                  ld_page,
  input  logic                  ld_offs,
  input  logic                  inc,
  input  logic [7:0]            code,
  input  logic                  wr_strobe,
  input  logic [DATA_W-1:0]     wdata,
  output logic [2*DATA_W-1:0]   addr,
  output logic                  fw
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [7:0]        page_q, page_n;
  logic              fw_q, fw_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic [ADDR_W-1:8] base_q, base_n;

  always_comb begin
    page_n = page_q;
    fw_n   = fw_q;
    ptr_n  = ptr_q;
    base_n = base_q;
    if (ld_direct) begin
      page_n = 8'h00;
      fw_n   = 1'b0;
      ptr_n  = code[PTR_W-1:0];
    end
    if (ld_page) begin
      if (code == FW_PAGE_CODE) begin
        page_n = FW_PAGE_CODE;
        fw_n   = 1'b1;
      end else begin
        page_n = code + 8'd1;
        fw_n   = 1'b0;
      end
    end
    if (ld_offs) ptr_n = code[PTR_W-1:0];
    if (inc)     ptr_n = ptr_q + 1'b1;
    // base words live on page 0 only
    if (wr_strobe && !fw_q && page_q == 8'h00) begin
      if (ptr_q == BASE_WORD)        base_n[ADDR_W-1:DATA_W] = wdata;
      if (ptr_q == BASE_WORD + 1'b1) base_n[DATA_W-1:8]      = wdata[DATA_W-1:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 8'h00;
      fw_q   <= 1'b0;
      ptr_q  <= '0;
      base_q <= '0;
    end else begin
      page_q <= page_n;
      fw_q   <= fw_n;
      ptr_q  <= ptr_n;
      base_q <= base_n;
    end
  end

  assign fw   = fw_q;
  assign addr = fw_q ? {base_q, ptr_q, 1'b0}
                     : {{(ADDR_W-16){1'b0}}, page_q, ptr_q, 1'b0};
endmodule

// File: rtl/psr_tx.sv
module psr_tx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] ldata,
  input  logic              sample,
  input  logic              fall,
  output logic              miso
);
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              pend_q, pend_n;

  // a bit is dropped only on the falling edge after the host sampled it
  always_comb begin
    sh_n   = sh_q;
    pend_n = pend_q;
    if (clr) begin
      sh_n   = '0;
      pend_n = 1'b0;
    end else if (load) begin
      sh_n   = ldata;
      pend_n = 1'b0;
    end else begin
      if (sample) pend_n = 1'b1;
      if (fall && pend_q) begin
        sh_n   = {sh_q[DATA_W-2:0], 1'b0};
        pend_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      pend_q <= pend_n;
    end
  end

  assign miso = sh_q[DATA_W-1];
endmodule

// File: rtl/paged_spi_regs.sv
module paged_spi_regs
  import psr_pkg::*;
#(
  parameter int               DATA_W      = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [PTR_W-1:0] BASE_WORD   = 7'd6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                reg_wr_en,
  output logic                reg_rd_en,
  output logic                reg_fw,
  output logic [2*DATA_W-1:0] reg_addr,
  output logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W-1:0]   reg_rdata
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [2:0] sync_q;
  logic       cs_s, sclk_s, mosi_s, cs_act;
  logic       sclk_d;
  logic       rise, fall;

  psr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sclk, spi_mosi}),
    .q     (sync_q)
  );

  assign cs_s   = sync_q[2];
  assign sclk_s = sync_q[1];
  assign mosi_s = sync_q[0];
  assign cs_act = ~cs_s;
  assign rise   = cs_act &  sclk_s & ~sclk_d;
  assign fall   = cs_act & ~sclk_s &  sclk_d;

  psr_state_e        state_q, state_n;
  logic [CNT_W-1:0]  bits_q, bits_n;
  logic [DATA_W-2:0] rx_q, rx_n;
  logic [PTR_W-1:0]  left_q, left_n;
  logic              wr_q, wr_n, rd_q, rd_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic              ld_direct, ld_page, ld_offs;
  logic [7:0]        in_byte;
  logic [DATA_W-1:0] in_word;
  logic              byte_done, word_done;

  assign in_byte   = {rx_q[6:0], mosi_s};
  assign in_word   = {rx_q, mosi_s};
  assign byte_done = (bits_q[2:0] == 3'd7);
  assign word_done = (bits_q == CNT_W'(DATA_W - 1));

  always_comb begin
    state_n   = state_q;
    bits_n    = bits_q;
    rx_n      = rx_q;
    left_n    = left_q;
    wr_n      = 1'b0;
    rd_n      = 1'b0;
    wdata_n   = wdata_q;
    ld_direct = 1'b0;
    ld_page   = 1'b0;
    ld_offs   = 1'b0;
    if (!cs_act) begin
      state_n = ST_CMD;
      bits_n  = '0;
    end else if (rise) begin
      rx_n   = {rx_q[DATA_W-3:0], mosi_s};
      bits_n = bits_q + 1'b1;
      unique case (state_q)
        ST_CMD: if (byte_done) begin
          bits_n = '0;
          if (in_byte == PAGED_ESCAPE) begin
            state_n = ST_PAGE;
          end else if (in_byte[7]) begin
            ld_direct = 1'b1;
            state_n   = ST_LEN;
          end else begin
            state_n = ST_DROP;
          end
        end
        ST_PAGE: if (byte_done) begin
          bits_n = '0;
          if (in_byte == PAGED_ESCAPE) begin
            state_n = ST_DROP;
          end else begin
            ld_page = 1'b1;
            state_n = ST_OFFS;
          end
        end
        ST_OFFS: if (byte_done) begin
          bits_n  = '0;
          ld_offs = 1'b1;
          state_n = ST_LEN;
        end
        ST_LEN: if (byte_done) begin
          bits_n = '0;
          left_n = in_byte[PTR_W-1:0];
          if (in_byte[7]) begin
            state_n = ST_WDATA;
          end else begin
            rd_n    = 1'b1;
            state_n = ST_RDATA;
          end
        end
        ST_WDATA: if (word_done) begin
          bits_n  = '0;
          wr_n    = 1'b1;
          wdata_n = in_word;
          if (left_q == '0) state_n = ST_DROP;
          else              left_n  = left_q - 1'b1;
        end
        ST_RDATA: if (word_done) begin
          bits_n = '0;
          if (left_q == '0) begin
            state_n = ST_DROP;
          end else begin
            left_n = left_q - 1'b1;
            rd_n   = 1'b1;
          end
        end
        default: bits_n = bits_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      bits_q  <= '0;
      rx_q    <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      sclk_d  <= 1'b0;
    end else begin
      state_q <= state_n;
      bits_q  <= bits_n;
      rx_q    <= rx_n;
      left_q  <= left_n;
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      wdata_q <= wdata_n;
      sclk_d  <= sclk_s;
    end
  end

  psr_addr #(.DATA_W(DATA_W), .BASE_WORD(BASE_WORD)) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_direct (ld_direct),
    .ld_page   (ld_page),
    .ld_offs   (ld_offs),
    .inc       (wr_q | rd_q),
    .code      (in_byte),
    .wr_strobe (wr_q),
    .wdata     (wdata_q),
    .addr      (reg_addr),
    .fw        (reg_fw)
  );

  psr_tx #(.DATA_W(DATA_W)) i_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!cs_act || state_q == ST_DROP),
    .load   (rd_q),
    .ldata  (reg_rdata),
    .sample (rise && state_q == ST_RDATA),
    .fall   (fall),
    .miso   (spi_miso)
  );

  assign reg_wr_en = wr_q;
  assign reg_rd_en = rd_q;
  assign reg_wdata = wdata_q;
endmodule

// File: rtl/psr_checker.sv
module psr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] addr_lo
);
  logic       seen_q;
  logic [7:0] last_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      last_lo_q <= 8'h00;
    end else if (cs_n) begin
      seen_q    <= 1'b0;
    end else if (wr_en || rd_en) begin
      seen_q    <= 1'b1;
      last_lo_q <= addr_lo;
    end
  end

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en}));

  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && seen_q) |-> (addr_lo == last_lo_q + 8'd2));

  assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!wr_en && !rd_en));

  assert_miso_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);
endmodule

bind paged_spi_regs psr_checker i_psr_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (spi_cs_n),
  .miso    (spi_miso),
  .wr_en   (reg_wr_en),
  .rd_en   (reg_rd_en),
  .addr_lo (reg_addr[7:0])
);

// File: tb/test_paged_spi_regs.sv
module test_paged_spi_regs;
  localparam int HALF = 8;

  logic        clk;
  logic        rst_n;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic        reg_wr_en, reg_rd_en, reg_fw;
  logic [31:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] exp_base = 32'h0;

  typedef struct {
    logic        wr;
    logic        fw;
    logic [31:0] addr;
    logic [15:0] data;
    string       req;
  } item_t;
  item_t exp_q[$];

  function automatic logic [15:0] mem_val(input logic [31:0] a, input logic f);
    return a[15:0] ^ a[31:16] ^ (f ? 16'hC0DE : 16'h3A5C);
  endfunction

  assign reg_rdata = mem_val(reg_addr, reg_fw);

  paged_spi_regs i_paged_spi_regs (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_fw(reg_fw), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: every strobe is compared against the next expected item
  always @(negedge clk) begin
    if (rst_n && (reg_wr_en || reg_rd_en)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 R10: unexpected strobe wr=%0d addr=%h, expected none",
                 reg_wr_en, reg_addr);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (reg_wr_en !== it.wr || reg_fw !== it.fw || reg_addr !== it.addr ||
            (it.wr && reg_wdata !== it.data)) begin
          errors++;
          $display("FAIL %s: strobe wr=%0d fw=%0d addr=%h data=%h, expected wr=%0d fw=%0d addr=%h data=%h",
                   it.req, reg_wr_en, reg_fw, reg_addr, reg_wdata, it.wr, it.fw, it.addr, it.data);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i];
      half();
      r[i] = spi_miso;
      spi_sclk = 1'b1;
      half();
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_on();
    spi_cs_n = 1'b0;
    half();
  endtask

  task automatic cs_off(input string req);
    half();
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic burst(input bit paged, input logic [7:0] pcode, input logic [6:0] offs,
                       input bit wr, input int n, input int extra,
                       input logic [15:0] seed, input string req);
    logic [7:0]  pg, hi, lo, junk;
    logic        fw;
    logic [6:0]  ptr;
    logic [31:0] a;
    logic [15:0] d;
    item_t       it;
    pg = paged ? ((pcode == 8'hFF) ? 8'hFF : pcode + 8'd1) : 8'h00;
    fw = paged && (pcode == 8'hFF);
    for (int k = 0; k < n; k++) begin
      ptr = offs + 7'(k);
      it.wr   = wr;
      it.fw   = fw;
      it.addr = fw ? {exp_base[31:8], ptr, 1'b0} : {16'h0000, pg, ptr, 1'b0};
      it.data = seed + 16'(k) * 16'h0203;
      it.req  = req;
      exp_q.push_back(it);
    end
    cs_on();
    if (paged) begin
      xfer(8'hFE, junk);
      xfer(pcode, junk);
      xfer({1'b0, offs}, junk);
    end else begin
      xfer({1'b1, offs}, junk);
    end
    xfer({wr, 7'(n - 1)}, junk);
    for (int k = 0; k < n + extra; k++) begin
      ptr = offs + 7'(k);
      a = fw ? {exp_base[31:8], ptr, 1'b0} : {16'h0000, pg, ptr, 1'b0};
      d = seed + 16'(k) * 16'h0203;
      if (wr) begin
        xfer(d[15:8], hi);
        xfer(d[7:0], lo);
      end else begin
        xfer(8'h00, hi);
        xfer(8'h00, lo);
        if (k < n) check({hi, lo} === mem_val(a, fw), {req, " R7 read data"}, {hi, lo}, mem_val(a, fw));
        else       check({hi, lo} === 16'h0000, "R12 R5 miso past count", {hi, lo}, 0);
      end
    end
    cs_off(req);
  endtask

  initial begin
    logic [7:0] r, acc;
    spi_cs_n = 1'b1;
    spi_sclk = 1'b0;
    spi_mosi = 1'b0;
    rst_n    = 1'b0;
    repeat (5) @(negedge clk);
    check(reg_wr_en === 1'b0 && reg_rd_en === 1'b0 && spi_miso === 1'b0, "R11 in reset",
          {reg_wr_en, reg_rd_en, spi_miso}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(reg_wr_en === 1'b0 && reg_rd_en === 1'b0 && spi_miso === 1'b0, "R11 after reset",
          {reg_wr_en, reg_rd_en, spi_miso}, 0);

    // direct page 0 bursts
    burst(0, 8'h00, 7'h10, 1, 3, 0, 16'hA1B2, "R1 R6 R8 direct write");
    burst(0, 8'h00, 7'h05, 0, 2, 0, 16'h0000, "R1 R7 R8 direct read");
    // paged access, page byte is page minus one
    burst(1, 8'h02, 7'h04, 1, 1, 0, 16'h5A5A, "R2 paged write");
    burst(1, 8'h00, 7'h7E, 0, 3, 0, 16'h0000, "R2 R8 paged read with wrap");
    burst(1, 8'hFD, 7'h01, 1, 2, 0, 16'h0F0F, "R2 top page write");
    // base for the firmware window
    burst(0, 8'h00, 7'h06, 1, 2, 0, 16'h1234, "R4 base write");
    exp_base = {16'h1234, 16'h1234 + 16'h0203};
    burst(1, 8'hFF, 7'h10, 1, 2, 0, 16'hBEEF, "R3 R4 firmware write");
    burst(1, 8'hFF, 7'h7F, 0, 2, 0, 16'h0000, "R3 R8 firmware read");
    // limits of the length byte
    burst(0, 8'h00, 7'h00, 1, 128, 1, 16'h0001, "R5 R8 max write burst");
    burst(0, 8'h00, 7'h20, 0, 2, 1, 16'h0000, "R5 R12 read past count");

    // invalid first byte
    cs_on();
    acc = 8'h00;
    xfer(8'h12, r); acc |= r;
    xfer(8'h81, r); acc |= r;
    for (int i = 0; i < 4; i++) begin xfer(8'h00, r); acc |= r; end
    check(acc === 8'h00, "R10 R12 miso on invalid first byte", acc, 0);
    cs_off("R10 invalid first byte no strobe");

    // reserved page byte
    cs_on();
    acc = 8'h00;
    xfer(8'hFE, r); xfer(8'hFE, r); xfer(8'h03, r); xfer(8'h00, r);
    for (int i = 0; i < 2; i++) begin xfer(8'h00, r); acc |= r; end
    check(acc === 8'h00, "R10 miso on reserved page byte", acc, 0);
    cs_off("R10 reserved page byte no strobe");

    // abort in the middle of the second word
    begin
      item_t it;
      it.wr = 1'b1; it.fw = 1'b0; it.addr = 32'h0000_0040; it.data = 16'hC3D4; it.req = "R9 abort first word";
      exp_q.push_back(it);
      cs_on();
      xfer(8'hA0, r); xfer(8'h81, r);
      xfer(8'hC3, r); xfer(8'hD4, r);
      xfer(8'h77, r);
      cs_off("R9 abort partial word no strobe");
    end
    burst(0, 8'h00, 7'h33, 0, 1, 0, 16'h0000, "R9 fresh header after abort");
    check(spi_miso === 1'b0, "R12 miso idle", spi_miso, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, all requirements unchecked");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule